// File: doc/BRIEF.md
# Multilevel Staircase Program Sequencer

This block sequences the programming of a word of two-bit-per-cell memory cells. A stepped gate voltage is represented by a step code. When a start pulse arrives, the block stores the write-buffer word and asks for a read of the addressed cells. It then compares every cell's present level with its target level.

Cells whose target is one of the two intermediate levels are handled first. Each one goes through a pulse-then-verify loop, and a cell leaves the program mask as soon as its verify result passes. Cells whose target is the fully charged level are handled after that. They get a ramp of pulses with no verify, and the ramp starts at the step where the verify loop stopped.

The block ends every operation with a one-cycle done pulse. Alongside it sit two error flags. One marks an illegal request, where a cell would have to move toward less charge. The other marks a verify loop that ran out of steps.

Top module: `mlsp_prog_seq`

## Requirements
- R1: After reset, `busy`, `done`, `rd_req`, `vfy_req`, `pgm_pulse`, both error flags and `pgm_mask` are 0, and `step_code` is 0.
- R2: A `start` seen while idle latches `wr_data` and raises `rd_req` once. `rd_req` is held until a cycle with `rd_valid`, in which `rd_data` is captured. Cell i occupies bits [2i+1:2i] of every word. The level codes in order of rising charge are 11 (erased), 10, 01, 00.
- R3: If any cell's target code holds less charge than its read-back code, the operation ends with `err_order` set. No program pulse and no verify request is issued in that case.
- R4: `step_code` restarts at 0 on every accepted start, only ever rises by 1, and never exceeds STEP_MAX (106 by default).
- R5: Each verify-loop step drives `pgm_pulse` for exactly PULSE_CYC cycles. One cycle of `vfy_req` follows, and the block then waits for `vfy_valid`. Each step of the final ramp drives `pgm_pulse` for PULSE_CYC cycles.
- R6: In the verify loop, the mask starts as the cells that target 10 or 01 and differ from their read-back code. A cell is dropped when its `vfy_pass` bit is 1 in a `vfy_valid` cycle, and it never returns.
- R7: The verify loop ends after the verify that empties the mask, and `step_code` is not advanced after that verify.
- R8: If a verify at step STEP_MAX leaves any cell in the mask, `err_fail` is set, the operation ends, and the final ramp is skipped.
- R9: The final ramp pulses the cells that target 00 and do not already read 00. It pulses once at each step from the last verify-loop step (0 if that loop did not run) through STEP_MAX, and no `vfy_req` is issued during it.
- R10: `busy` is high from the cycle after an accepted start until the end of the cycle in which `done` is high. `done` is high for one cycle. The error flags keep their value until the next accepted start.
- R11: Cells whose target equals their read-back code, or whose target is 11, are never in `pgm_mask`. A word needing no change finishes with no pulse at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| start | input | 1 | Begin a program operation (accepted when idle) |
| wr_data | input | 2*NCELL | Target levels, two bits per cell |
| rd_req | output | 1 | Request for a read of the addressed cells |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | 2*NCELL | Present levels of the cells |
| step_code | output | clog2(STEP_MAX+1) | Gate voltage step index |
| pgm_pulse | output | 1 | Program pulse active |
| pgm_mask | output | NCELL | Cells receiving the current pulse |
| vfy_req | output | 1 | One-cycle verify request |
| vfy_valid | input | 1 | Verify result valid |
| vfy_pass | input | NCELL | Per-cell verify pass |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| err_order | output | 1 | Request would lower a cell's charge |
| err_fail | output | 1 | Verify loop ran out of steps |

## Verification
A mask register that drops a cell too early or too late shows up directly on `pgm_mask`. The error appears in the first pulse after the faulty verify, no more than PULSE_CYC plus three cycles later. A step counter that slips or fails to hold at the end of the verify loop moves the start of the final ramp. That error shows on `step_code` in the first ramp pulse, and in the count of ramp steps at `done`. A wrong comparison decision is visible in the very first pulse, or in the error flags at `done` when no pulse is issued.

// File: rtl/mlsp_pkg.sv
package mlsp_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_READ,
    S_CMP,
    S_P2_PULSE,
    S_P2_VREQ,
    S_P2_VWAIT,
    S_P3_PULSE,
    S_FIN
  } seq_state_e;

  // Charge order: 11 erased (0) < 10 (1) < 01 (2) < 00 (3)
  function automatic logic [1:0] charge_rank(input logic [1:0] code);
    return ~code;
  endfunction

  function automatic logic is_mid_level(input logic [1:0] code);
    return (code == 2'b10) || (code == 2'b01);
  endfunction

  function automatic logic is_top_level(input logic [1:0] code);
    return code == 2'b00;
  endfunction

endpackage

// File: rtl/mlsp_cell_cmp.sv
module mlsp_cell_cmp
  import mlsp_pkg::*;
#(
  parameter int NCELL = 8
) (
  input  logic [2*NCELL-1:0] tgt_word,
  input  logic [2*NCELL-1:0] cur_word,
  output logic [NCELL-1:0]   mid_mask,
  output logic [NCELL-1:0]   top_mask,
  output logic [NCELL-1:0]   order_bad
);

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    logic [1:0] tgt_c;
    logic [1:0] cur_c;
    assign tgt_c = tgt_word[2*i +: 2];
    assign cur_c = cur_word[2*i +: 2];
    // R3: target holding less charge than present content is illegal
    assign order_bad[i] = charge_rank(tgt_c) < charge_rank(cur_c);
    // R6 / R11: intermediate targets that differ from the present content
    assign mid_mask[i]  = is_mid_level(tgt_c) && (tgt_c != cur_c);
    // R9 / R11: fully charged target not yet reached
    assign top_mask[i]  = is_top_level(tgt_c) && !is_top_level(cur_c);
  end

endmodule

// File: rtl/mlsp_stair_ctr.sv
module mlsp_stair_ctr #(
  parameter int STEP_MAX = 106,
  parameter int SW       = $clog2(STEP_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [SW-1:0] step,
  output logic          at_top
);

  assign at_top = (step == SW'(STEP_MAX));

  always_ff @(posedge clk) begin
    if (!rst_n)              step <= '0;
    else if (clr)            step <= '0;
    else if (inc && !at_top) step <= step + 1'b1;
  end

  a_r4_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    step <= SW'(STEP_MAX));

  a_r4_step_plus_one: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (step == $past(step)) || (step == $past(step) + 1'b1));

endmodule

// File: rtl/mlsp_pulse_tmr.sv
module mlsp_pulse_tmr #(
  parameter int PULSE_CYC = 3,
  parameter int CW        = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);

  logic [CW-1:0] cnt;

  assign last = run && (cnt == CW'(PULSE_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (last) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(PULSE_CYC) || PULSE_CYC == 1);

  a_r5_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);

endmodule

// File: rtl/mlsp_prog_seq.sv
module mlsp_prog_seq
  import mlsp_pkg::*;
#(
  parameter int NCELL     = 8,
  parameter int STEP_MAX  = 106,
  parameter int PULSE_CYC = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [2*NCELL-1:0]            wr_data,
  output logic                          rd_req,
  input  logic                          rd_valid,
  input  logic [2*NCELL-1:0]            rd_data,
  output logic [$clog2(STEP_MAX+1)-1:0] step_code,
  output logic                          pgm_pulse,
  output logic [NCELL-1:0]              pgm_mask,
  output logic                          vfy_req,
  input  logic                          vfy_valid,
  input  logic [NCELL-1:0]              vfy_pass,
  output logic                          busy,
  output logic                          done,
  output logic                          err_order,
  output logic                          err_fail
);

  localparam int W  = 2 * NCELL;
  localparam int SW = $clog2(STEP_MAX + 1);

  seq_state_e       state_q;
  logic [W-1:0]     wr_q, cur_q;
  logic [NCELL-1:0] mask_q, top_q;
  logic             err_order_q, err_fail_q;

  logic [NCELL-1:0] mid_mask, top_mask, order_bad;
  logic             order_err;
  logic [SW-1:0]    step;
  logic             at_top, pulse_last, pulse_run;

  // Named internal events
  logic             start_acc, rd_take, vfy_take, p2_clear, p2_fail, p3_end;
  logic             inc_step, p2_active;
  logic [NCELL-1:0] mask_left;

  mlsp_cell_cmp #(.NCELL(NCELL)) u_cmp (
    .tgt_word (wr_q),
    .cur_word (cur_q),
    .mid_mask (mid_mask),
    .top_mask (top_mask),
    .order_bad(order_bad)
  );

  assign order_err = |order_bad;

  assign start_acc = (state_q == S_IDLE) && start;
  assign rd_take   = (state_q == S_READ) && rd_valid;
  assign vfy_take  = (state_q == S_P2_VWAIT) && vfy_valid;
  assign mask_left = mask_q & ~vfy_pass;
  assign p2_clear  = vfy_take && (mask_left == '0);
  assign p2_fail   = vfy_take && !p2_clear && at_top;
  assign p3_end    = (state_q == S_P3_PULSE) && pulse_last && at_top;
  assign inc_step  = (vfy_take && !p2_clear) ||
                     ((state_q == S_P3_PULSE) && pulse_last);
  assign pulse_run = (state_q == S_P2_PULSE) || (state_q == S_P3_PULSE);
  assign p2_active = (state_q == S_P2_PULSE) || (state_q == S_P2_VREQ) ||
                     (state_q == S_P2_VWAIT);

  mlsp_stair_ctr #(.STEP_MAX(STEP_MAX), .SW(SW)) u_stair (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start_acc),
    .inc   (inc_step),
    .step  (step),
    .at_top(at_top)
  );

  mlsp_pulse_tmr #(.PULSE_CYC(PULSE_CYC)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (pulse_run),
    .last (pulse_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      wr_q        <= '0;
      cur_q       <= '0;
      mask_q      <= '0;
      top_q       <= '0;
      err_order_q <= 1'b0;
      err_fail_q  <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start_acc) begin
          wr_q        <= wr_data;
          err_order_q <= 1'b0;
          err_fail_q  <= 1'b0;
          state_q     <= S_READ;
        end
        S_READ: if (rd_take) begin
          cur_q   <= rd_data;
          state_q <= S_CMP;
        end
        S_CMP: begin
          top_q <= top_mask;
          if (order_err) begin
            err_order_q <= 1'b1;
            state_q     <= S_FIN;
          end else if (|mid_mask) begin
            mask_q  <= mid_mask;
            state_q <= S_P2_PULSE;
          end else if (|top_mask) begin
            mask_q  <= top_mask;
            state_q <= S_P3_PULSE;
          end else begin
            state_q <= S_FIN;
          end
        end
        S_P2_PULSE: if (pulse_last) state_q <= S_P2_VREQ;
        S_P2_VREQ:  state_q <= S_P2_VWAIT;
        S_P2_VWAIT: if (vfy_take) begin
          if (p2_clear) begin
            if (|top_q) begin
              mask_q  <= top_q;
              state_q <= S_P3_PULSE;
            end else begin
              mask_q  <= '0;
              state_q <= S_FIN;
            end
          end else if (p2_fail) begin
            mask_q     <= mask_left;
            err_fail_q <= 1'b1;
            state_q    <= S_FIN;
          end else begin
            mask_q  <= mask_left;
            state_q <= S_P2_PULSE;
          end
        end
        S_P3_PULSE: if (p3_end) state_q <= S_FIN;
        S_FIN:      state_q <= S_IDLE;
        default:    state_q <= S_IDLE;
      endcase
    end
  end

  assign rd_req    = (state_q == S_READ);
  assign vfy_req   = (state_q == S_P2_VREQ);
  assign pgm_pulse = pulse_run;
  assign pgm_mask  = pulse_run ? mask_q : '0;
  assign step_code = step;
  assign busy      = (state_q != S_IDLE);
  assign done      = (state_q == S_FIN);
  assign err_order = err_order_q;
  assign err_fail  = err_fail_q;

  a_r2_read_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> rd_req);

  a_r3_no_pulse_on_order: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_pulse |-> !err_order);

  a_r5_vreq_single: assert property (@(posedge clk) disable iff (!rst_n)
    vfy_req |=> !vfy_req);

  a_r5_pulse_has_cells: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_pulse |-> (pgm_mask != '0));

  a_r6_mask_never_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (p2_active && $past(p2_active)) |-> ((mask_q & ~$past(mask_q)) == '0));

  a_r8_fail_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_fail) |-> (step_code == SW'(STEP_MAX)));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_mask_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (p2_active && $past(p2_active)) |-> ((mask_q & ~mid_mask) == '0));

endmodule

// File: tb/mlsp_prog_seq_test.sv
module mlsp_prog_seq_test;
  localparam int N    = 8;
  localparam int SMAX = 106;
  localparam int PC   = 3;
  localparam int NB   = 400;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, start, rd_req, rd_valid, pgm_pulse, vfy_req, vfy_valid;
  logic          busy, done, err_order, err_fail;
  logic [2*N-1:0] wr_data, rd_data;
  logic [6:0]    step_code;
  logic [N-1:0]  pgm_mask, vfy_pass;

  mlsp_prog_seq #(.NCELL(N), .STEP_MAX(SMAX), .PULSE_CYC(PC)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .wr_data(wr_data),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
    .step_code(step_code), .pgm_pulse(pgm_pulse), .pgm_mask(pgm_mask),
    .vfy_req(vfy_req), .vfy_valid(vfy_valid), .vfy_pass(vfy_pass),
    .busy(busy), .done(done), .err_order(err_order), .err_fail(err_fail)
  );

  int n_chk = 0, n_fail = 0;
  int k[N];
  int thr10, thr01;
  logic [2*N-1:0] cur_word, case_wr;
  int b_step[NB], b_mask[NB], b_len[NB];
  int nb, vreq_cnt, rd_cnt, prev_step, vdly;
  bit prev_pulse, prev_rd, vpend;
  int e_step[NB], e_mask[NB];
  int ne, exp_vfy, exp_final;
  bit exp_order, exp_fail;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int lvl(input logic [2*N-1:0] w, input int i);
    return int'((w >> (2*i)) & 2'b11);
  endfunction

  // Step at which a cell's verify first passes
  function automatic int need_of(input int i);
    int t = lvl(case_wr, i);
    if (t == 2) return thr10 - k[i];
    if (t == 1) return thr01 - k[i];
    return 1 << 20;
  endfunction

  task automatic build_expect();
    int mid = 0, top = 0, last = 0;
    exp_order = 0; exp_fail = 0; ne = 0; exp_vfy = 0; exp_final = 0;
    for (int i = 0; i < N; i++) begin
      int c = lvl(cur_word, i), t = lvl(case_wr, i);
      if ((3 - t) < (3 - c)) exp_order = 1;
      if (t != c && (t == 2 || t == 1)) mid |= (1 << i);
      if (t == 0 && c != 0) top |= (1 << i);
    end
    if (exp_order) return;
    if (mid != 0) begin
      for (int i = 0; i < N; i++)
        if (mid[i] && need_of(i) > last) last = need_of(i);
      if (last > SMAX) begin exp_fail = 1; last = SMAX; end
      for (int s = 0; s <= last; s++) begin
        int m = 0;
        for (int i = 0; i < N; i++) if (mid[i] && need_of(i) >= s) m |= (1 << i);
        e_step[ne] = s; e_mask[ne] = m; ne++;
      end
      exp_vfy = last + 1;
    end
    exp_final = last;
    if (!exp_fail && top != 0) begin
      for (int s = last; s <= SMAX; s++) begin
        e_step[ne] = s; e_mask[ne] = top; ne++;
      end
      exp_final = SMAX;
    end
  endtask

  // Monitor and responder, all at the falling edge
  initial begin
    rd_valid = 0; rd_data = '0; vfy_valid = 0; vfy_pass = '0;
    vpend = 0; vdly = 0; nb = 0; vreq_cnt = 0; rd_cnt = 0;
    prev_pulse = 0; prev_rd = 0; prev_step = 0;
    forever begin
      @(negedge clk);
      if (pgm_pulse) begin
        if (!prev_pulse || int'(step_code) != prev_step) begin
          if (nb < NB) begin
            b_step[nb] = int'(step_code); b_mask[nb] = int'(pgm_mask); b_len[nb] = 1;
          end
          nb++;
        end else if (nb > 0 && nb <= NB) b_len[nb-1]++;
      end
      prev_pulse = pgm_pulse; prev_step = int'(step_code);
      if (vfy_req) vreq_cnt++;
      if (rd_req && !prev_rd) rd_cnt++;
      prev_rd = rd_req;
      if (rd_valid) rd_valid = 0;
      else if (rd_req) begin rd_valid = 1; rd_data = cur_word; end
      if (vfy_valid) vfy_valid = 0;
      else if (vpend) begin
        if (vdly == 0) begin
          for (int i = 0; i < N; i++) vfy_pass[i] = (int'(step_code) >= need_of(i));
          vfy_valid = 1; vpend = 0;
        end else vdly--;
      end
      if (vfy_req) begin vpend = 1; vdly = int'($urandom % 3); end
    end
  end

  task automatic run_case(input string nm, input logic [2*N-1:0] cur,
                          input logic [2*N-1:0] wr);
    bit got = 0;
    int bad_s = 0, bad_l = 0, bad_m = 0;
    cur_word = cur; case_wr = wr;
    build_expect();
    @(negedge clk);
    wr_data = wr; start = 1; nb = 0; vreq_cnt = 0; rd_cnt = 0;
    @(negedge clk);
    start = 0;
    check(busy == 1'b1, "R10", {nm, " busy after start"}, busy, 1);
    for (int c = 0; c < 20000 && !got; c++) begin
      @(negedge clk);
      if (done) got = 1;
    end
    check(got, "R10", {nm, " done seen"}, got, 1);
    if (!got) return;
    check(err_order == exp_order, "R3", {nm, " err_order"}, err_order, exp_order);
    check(err_fail == exp_fail, "R8", {nm, " err_fail"}, err_fail, exp_fail);
    check(int'(step_code) == exp_final, "R4", {nm, " final step"}, step_code, exp_final);
    check(rd_cnt == 1, "R2", {nm, " read requests"}, rd_cnt, 1);
    check(vreq_cnt == exp_vfy, "R5", {nm, " verify requests"}, vreq_cnt, exp_vfy);
    check(nb == ne, "R9 R11", {nm, " pulse steps"}, nb, ne);
    for (int j = 0; j < nb && j < ne && j < NB; j++) begin
      if (b_step[j] != e_step[j]) bad_s++;
      if (b_len[j] != PC) bad_l++;
      if (b_mask[j] != e_mask[j]) bad_m++;
    end
    check(bad_s == 0, "R7", {nm, " step sequence mismatches"}, bad_s, 0);
    check(bad_l == 0, "R5", {nm, " pulse length mismatches"}, bad_l, 0);
    check(bad_m == 0, "R6", {nm, " mask mismatches"}, bad_m, 0);
    repeat (3) @(negedge clk);
    check(!busy && !done, "R10", {nm, " idle after done"}, {busy, done}, 0);
    check(err_order == exp_order && err_fail == exp_fail, "R10", {nm, " errors held"},
          {err_order, err_fail}, {exp_order, exp_fail});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog expired: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; start = 0; wr_data = '0; cur_word = '0; case_wr = '0;
    thr10 = 20; thr01 = 45;
    for (int i = 0; i < N; i++) k[i] = int'($urandom % 8);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !done && !rd_req && !vfy_req, "R1", "control outputs after reset",
          {busy, done, rd_req, vfy_req}, 0);
    check(!pgm_pulse && pgm_mask == '0, "R1", "pulse outputs after reset",
          {pgm_pulse, pgm_mask}, 0);
    check(step_code == '0 && !err_order && !err_fail, "R1", "step and errors after reset",
          {step_code, err_order, err_fail}, 0);

    run_case("mixed", 16'hFFFF, 16'hC6C6);
    run_case("order_error", 16'hFFFC, 16'hFFFE);
    thr01 = 200;
    run_case("verify_fail", 16'hFFFF, 16'hFFF1);
    thr01 = 45;
    run_case("no_change", 16'h5A3C, 16'h5A3C);
    run_case("erased_target", 16'hFFFF, 16'hFFFF);
    run_case("top_only", 16'hFFFF, 16'h00FF);
    run_case("partial", 16'hFFE6, 16'hFFC1);
    check(exp_vfy > 0 && nb > 0, "R11", "partial case issued pulses", nb, ne);

    for (int r = 0; r < 8; r++) begin
      logic [2*N-1:0] c_w, t_w;
      thr10 = 5 + int'($urandom % 30);
      thr01 = thr10 + 5 + int'($urandom % 30);
      for (int i = 0; i < N; i++) begin
        int cl = int'($urandom % 4);
        int rc = 3 - cl;
        int rt = rc + int'($urandom % (4 - rc));
        c_w[2*i +: 2] = 2'(cl);
        t_w[2*i +: 2] = 2'(3 - rt);
        k[i] = int'($urandom % 8);
      end
      run_case($sformatf("random%0d", r), c_w, t_w);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule